// File: doc/BRIEF.md
# Core Timebase Prescaler

This block produces the shared timebase that the per-core timers compare against. One of two tick strobes is picked as the source: a crystal-derived strobe (nominally 19.2 MHz) or an alternate strobe derived from the bus clock. Each source tick that is picked then passes through a fractional rate scaler before it moves a free-running counter. The counter moves by one or by two for each tick that leaves the scaler.

The scaler is a phase accumulator. The ratio input is added to it on every source tick that is picked. Each time the sum passes a multiple of 2^31, one tick leaves the scaler. The output rate is therefore the source rate times ratio / 2^31. A ratio of 0x80000000 passes ticks one for one, and ratios above that can release two ticks from a single source tick. The counter output and a one-cycle count-enable strobe are both registered and change on the clock edge that samples the source tick.

Top module: `timebase_prescaler`

## Requirements
- R1: Synchronous active-high reset clears the counter, the accumulator phase and the count-enable strobe to zero.
- R2: With `src_alt` low, only `xtal_tick` feeds the scaler, and `alt_tick` has no effect on the counter.
- R3: With `src_alt` high, only `alt_tick` feeds the scaler, and `xtal_tick` has no effect on the counter.
- R4: With ratio 0x80000000, every source tick that is picked advances the counter by one step. The new count and a high `count_en` appear together one clock after the tick is sampled.
- R5: A ratio below 0x80000000 releases ticks at the fraction ratio / 2^31. For example, 0x40000000 advances the counter on every second source tick.
- R6: With `step_dbl` high, each released tick adds 2 to the counter instead of 1.
- R7: A ratio of zero freezes the counter, and `count_en` stays low.
- R8: A ratio above 0x80000000 can release two ticks from one source tick. With 0xC0000000 and a cleared phase, two source ticks advance the counter by 1 and then by 2.
- R9: The counter is CNT_W bits wide (64 by default) and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_tick | input | 1 | Crystal-derived tick strobe |
| alt_tick | input | 1 | Alternate bus-derived tick strobe |
| src_alt | input | 1 | 0 selects the crystal tick, 1 selects the alternate tick |
| step_dbl | input | 1 | 0 steps by one, 1 steps by two |
| ratio | input | RATIO_W | Fractional scale, 2^31 represents 1.0 |
| count | output | CNT_W | Timebase counter |
| count_en | output | 1 | High for one cycle when the counter has just advanced |

## Verification
Two increments can coincide in a single cycle. A ratio above one half releases two scaler ticks at once, and double-step mode then turns that into a jump of up to four. If the counter is near its top, that jump crosses the wrap point in the same cycle. The bench builds the counter with a narrow width and drives ratio 0xFFFFFFFF in double-step mode until the count rolls over. It compares every cycle against an independent model of the arithmetic modulo 2^CNT_W, so a lost carry or a truncated increment at the wrap is reported as a mismatch.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_ALT  = 1'b1
    } tb_src_e;

    typedef struct packed {
        tb_src_e src;
        logic    dbl;
    } tb_mode_t;

    // Number of scaler ticks released in one cycle: 0, 1 or 2.
    typedef logic [1:0] tb_carry_t;
    // Counter increment for one cycle: 0 to 4.
    typedef logic [2:0] tb_inc_t;

    function automatic tb_inc_t step_amount(tb_carry_t n, logic dbl);
        return dbl ? {n, 1'b0} : {1'b0, n};
    endfunction

endpackage

// File: rtl/tb_src_mux.sv
module tb_src_mux
    import timebase_pkg::*;
(
    input  logic    xtal_tick,
    input  logic    alt_tick,
    input  tb_src_e src,
    output logic    src_tick
);
    always_comb begin
        unique case (src)
            SRC_XTAL: src_tick = xtal_tick;
            SRC_ALT:  src_tick = alt_tick;
            default:  src_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tb_phase_acc.sv
module tb_phase_acc
    import timebase_pkg::*;
#(
    parameter int RATIO_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               src_tick,
    input  logic [RATIO_W-1:0] ratio,
    output tb_carry_t          carries
);
    localparam int PH_W  = RATIO_W - 1;
    localparam int SUM_W = RATIO_W + 1;

    logic [PH_W-1:0]  phase_q;
    logic [SUM_W-1:0] sum;

    assign sum     = {2'b00, phase_q} + {1'b0, ratio};
    assign carries = src_tick ? tb_carry_t'(sum[SUM_W-1:PH_W]) : tb_carry_t'(0);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (src_tick)
            phase_q <= sum[PH_W-1:0];
    end

    // R5
    no_idle_carry_chk: assert property (@(posedge clk) disable iff (rst)
        !src_tick |-> carries == 2'd0);
endmodule

// File: rtl/tb_step_counter.sv
module tb_step_counter
    import timebase_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  tb_inc_t          inc,
    output logic [CNT_W-1:0] count,
    output logic             count_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            count_en <= 1'b0;
        end else begin
            count    <= count + CNT_W'(inc);
            count_en <= (inc != '0);
        end
    end

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !count_en |-> $stable(count));
endmodule

// File: rtl/timebase_prescaler.sv
module timebase_prescaler
    import timebase_pkg::*;
#(
    parameter int RATIO_W = 32,
    parameter int CNT_W   = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               xtal_tick,
    input  logic               alt_tick,
    input  logic               src_alt,
    input  logic               step_dbl,
    input  logic [RATIO_W-1:0] ratio,
    output logic [CNT_W-1:0]   count,
    output logic               count_en
);
    tb_mode_t  mode;
    logic      src_tick;
    tb_carry_t carries;
    tb_inc_t   inc;

    assign mode.src = tb_src_e'(src_alt);
    assign mode.dbl = step_dbl;

    tb_src_mux u_mux (
        .xtal_tick (xtal_tick),
        .alt_tick  (alt_tick),
        .src       (mode.src),
        .src_tick  (src_tick)
    );

    tb_phase_acc #(.RATIO_W(RATIO_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .src_tick (src_tick),
        .ratio    (ratio),
        .carries  (carries)
    );

    assign inc = step_amount(carries, mode.dbl);

    tb_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .inc      (inc),
        .count    (count),
        .count_en (count_en)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && !count_en));

    // R7
    zero_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (ratio == '0) |=> ($stable(count) && !count_en));

    // R2
    xtal_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!src_alt && !xtal_tick) |=> $stable(count));

    // R3
    alt_only_chk: assert property (@(posedge clk) disable iff (rst)
        (src_alt && !alt_tick) |=> $stable(count));

    // R6
    even_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_dbl && !count[0]) |=> !count[0]);
endmodule

// File: tb/sim_timebase_prescaler.sv
`timescale 1ns/1ps
module sim_timebase_prescaler;
    localparam int CW = 12;
    localparam int NV = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xtal_tick = 1'b0, alt_tick = 1'b0, src_alt = 1'b0, step_dbl = 1'b0;
    logic [31:0] ratio = 32'h8000_0000;
    logic [CW-1:0] count;
    logic count_en;

    int checks = 0;
    int fails  = 0;
    longint m_ph  = 0;
    longint m_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    timebase_prescaler #(.RATIO_W(32), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .xtal_tick(xtal_tick), .alt_tick(alt_tick),
        .src_alt(src_alt), .step_dbl(step_dbl), .ratio(ratio),
        .count(count), .count_en(count_en)
    );

    // {src_alt, step_dbl, ratio, xtal_tick, alt_tick}
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b0},
        {1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b1},
        {1'b1, 1'b0, 32'h8000_0000, 1'b1, 1'b0},
        {1'b1, 1'b0, 32'h8000_0000, 1'b0, 1'b1},
        {1'b0, 1'b1, 32'h2000_0000, 1'b1, 1'b1},
        {1'b0, 1'b1, 32'h2000_0000, 1'b1, 1'b0},
        {1'b0, 1'b1, 32'h2000_0000, 1'b1, 1'b0},
        {1'b0, 1'b1, 32'h2000_0000, 1'b1, 1'b0},
        {1'b1, 1'b0, 32'h5555_5555, 1'b0, 1'b1},
        {1'b1, 1'b0, 32'h5555_5555, 1'b0, 1'b1},
        {1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b1},
        {1'b1, 1'b1, 32'hE000_0000, 1'b0, 1'b1},
        {1'b1, 1'b1, 32'hE000_0000, 1'b0, 1'b1},
        {1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0},
        {1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0},
        {1'b0, 1'b1, 32'h8000_0001, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, update the reference model, then check.
    task automatic step(input logic sa, input logic sd, input logic [31:0] r,
                        input logic xt, input logic at, input string req);
        longint sum, n, inc;
        @(negedge clk);
        src_alt = sa; step_dbl = sd; ratio = r; xtal_tick = xt; alt_tick = at;
        inc = 0;
        if (sa ? at : xt) begin
            sum  = m_ph + longint'(r);
            n    = sum >> 31;
            m_ph = sum & 64'h7FFF_FFFF;
            inc  = sd ? 2 * n : n;
        end
        m_cnt = (m_cnt + inc) % (64'd1 << CW);
        @(posedge clk);
        #1;
        chk(req, longint'(count), m_cnt);
        chk(req, longint'(count_en), (inc != 0) ? 1 : 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; xtal_tick = 1'b0; alt_tick = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        chk("R1 count", longint'(count), 0);
        chk("R1 count_en", longint'(count_en), 0);
        @(negedge clk);
        rst = 1'b0;
        m_ph = 0; m_cnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        longint prev;
        do_reset();

        // R2: alternate strobe ignored while the crystal tick is picked
        step(1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b1, "R2 alt ignored");
        chk("R2 literal", longint'(count), 0);
        step(1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b0, "R4 one-to-one");
        chk("R4 literal", longint'(count), 1);
        // R3: crystal strobe ignored while the alternate tick is picked
        step(1'b1, 1'b0, 32'h8000_0000, 1'b1, 1'b0, "R3 xtal ignored");
        chk("R3 literal", longint'(count), 1);
        step(1'b1, 1'b0, 32'h8000_0000, 1'b0, 1'b1, "R3 alt counts");
        chk("R3 literal2", longint'(count), 2);
        // R6: double step
        step(1'b1, 1'b1, 32'h8000_0000, 1'b0, 1'b1, "R6 double");
        chk("R6 literal", longint'(count), 4);
        // R7: zero ratio freezes
        step(1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b1, "R7 zero ratio");
        step(1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b1, "R7 zero ratio");
        chk("R7 literal", longint'(count), 4);
        // R5: half rate
        step(1'b1, 1'b0, 32'h4000_0000, 1'b0, 1'b1, "R5 half rate a");
        chk("R5 literal a", longint'(count), 4);
        step(1'b1, 1'b0, 32'h4000_0000, 1'b0, 1'b1, "R5 half rate b");
        chk("R5 literal b", longint'(count), 5);
        // R8: ratio 1.5 releases 1 then 2
        step(1'b1, 1'b0, 32'hC000_0000, 1'b0, 1'b1, "R8 first");
        chk("R8 literal a", longint'(count), 6);
        step(1'b1, 1'b0, 32'hC000_0000, 1'b0, 1'b1, "R8 second");
        chk("R8 literal b", longint'(count), 8);

        // Table of mixed vectors against the model
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][35], VEC[i][34], VEC[i][33:2], VEC[i][1], VEC[i][0],
                 "R5 R6 R8 vector");
        end

        // R9: wrap at 2^CW with the largest increments
        prev = m_cnt;
        for (int k = 0; k < 1200; k++) begin
            step(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9 wrap");
            if (m_cnt < prev) begin
                chk("R9 wrapped below", (longint'(count) < prev) ? 1 : 0, 1);
                break;
            end
            prev = m_cnt;
        end
        step(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9 after wrap");

        // R1: reset in mid-run
        do_reset();
        step(1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b0, "R1 restart");
        chk("R1 restart literal", longint'(count), 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule